// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator

This block produces one pulse-width modulated output from the master clock. A channel tick sets the pace of an internal counter. The tick comes from one of eleven power-of-two taps of a free-running prescaler, or from one of two independent linear dividers. A period value and a duty value shape the waveform. In edge mode the counter ramps up and wraps. In symmetric mode it ramps up and then back down, which doubles the period and places the active window in the middle of it. A mode bit selects the idle level that the output holds at the start of every period.

Software programs the block through a four-entry write port. Period, duty, alignment and polarity are written into holding registers, and the counter copies them into its working set only at a period boundary, so a change never cuts a pulse short. The clock selection and the divider values act at once. A single-cycle pulse marks the first master-clock cycle of every period so that neighbouring logic can follow the waveform.

Top module: `pwm_chan_gen`

## Requirements
- R1: While reset is low and in the cycle after it, the output is low and the period pulse is low. After reset the block uses tap 0 (one tick per master cycle), edge mode, idle level low, period 1 and duty 0.
- R2: Register 0 (mode) holds the clock select in bits [3:0], the symmetric-mode flag in bit 4 and the idle level in bit 5. A select value k from 0 to 10 gives one tick every 2^k master cycles, so an edge-mode period with period value P lasts 2^k × P master cycles.
- R3: Select value 11 uses divider A and select value 12 uses divider B. Register 3 holds divider A in bits [7:0] and divider B in bits [15:8]. A divider value N gives one tick every N master cycles, with N = 0 treated as 1. Select values 13 to 15 tick every master cycle.
- R4: In edge mode, with period P (register 1) and duty D (register 2), tick index t of a period runs from 0 to P−1. The output is at the idle level for t < P−D and at the opposite level for t ≥ P−D.
- R5: In symmetric mode a period has 2×P ticks. The output is at the opposite level exactly for tick indices P−D through P+D−1, a window centred in the period.
- R6: With the idle-level bit set, every waveform of R4 and R5 appears inverted and starts high.
- R7: Duty 0 holds the idle level for the whole period. Duty equal to the period holds the opposite level for the whole period.
- R8: Writes to period, duty, alignment and idle level take effect at the start of the next period. A write that lands on the clock edge that ends a period takes effect one period later.
- R9: The period pulse is high during exactly the first master-clock cycle of each period and low in every other cycle of that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 period, 2 duty, 3 dividers |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Modulated output |
| period_evt | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
A register write can land on the same clock edge as the period wrap that copies the holding registers into the working set. The bench provokes this with one tick per master cycle by writing a new duty in the last cycle of a period. It then compares two complete periods cycle by cycle against the formula: the period that follows still has to show the old duty, and only the one after it the new duty. A write in the middle of a period is also checked. The rest of that period must keep its old shape.

// File: rtl/pwm_pkg.sv
// Package: shared register codes and mode layout for the PWM channel.
// Assumes the write data bus is wide enough for the mode fields and the two
// divider values side by side.
package pwm_pkg;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_DUTY   = 2'd2,
        REG_DIV    = 2'd3
    } pwm_reg_e;

    typedef struct packed {
        logic       idle_high;
        logic       centre;
        logic [3:0] clk_sel;
    } pwm_mode_t;

    localparam int MODE_W = 6;

endpackage

// File: rtl/pwm_regs.sv
// pwm_regs: register file for the channel. Clock select and dividers act at
// once. Period, duty, alignment and idle level sit in holding registers and
// are copied into the working set when 'load' is high (period wrap).
// Assumes RST_PRD >= 1. A zero period is stored as 1 so the counter always
// has a valid end point.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int DW      = 16,
    parameter int DIV_W   = 8,
    parameter int RST_PRD = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             load,
    output logic [3:0]       clk_sel,
    output logic [DIV_W-1:0] div_a,
    output logic [DIV_W-1:0] div_b,
    output logic [DW-1:0]    act_prd,
    output logic [DW-1:0]    act_dty,
    output logic             act_centre,
    output logic             act_idle
);

    localparam logic [DW-1:0] PRD_INIT = DW'(RST_PRD);
    localparam logic [DW-1:0] ONE      = DW'(1);

    pwm_mode_t        mode_q;
    logic [DW-1:0]    prd_hold_q;
    logic [DW-1:0]    dty_hold_q;
    logic [DIV_W-1:0] div_a_q;
    logic [DIV_W-1:0] div_b_q;

    // Capture software writes into the immediate and holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            prd_hold_q <= PRD_INIT;
            dty_hold_q <= '0;
            div_a_q    <= '0;
            div_b_q    <= '0;
        end else if (wr_en) begin
            case (pwm_reg_e'(wr_addr))
                REG_MODE:   mode_q     <= pwm_mode_t'(wr_data[MODE_W-1:0]);
                REG_PERIOD: prd_hold_q <= wr_data;
                REG_DUTY:   dty_hold_q <= wr_data;
                REG_DIV: begin
                    div_a_q <= wr_data[DIV_W-1:0];
                    div_b_q <= wr_data[2*DIV_W-1:DIV_W];
                end
                default: ;
            endcase
        end
    end

    // Copy the holding registers into the working set at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_prd    <= PRD_INIT;
            act_dty    <= '0;
            act_centre <= 1'b0;
            act_idle   <= 1'b0;
        end else if (load) begin
            act_prd    <= (prd_hold_q == '0) ? ONE : prd_hold_q;
            act_dty    <= dty_hold_q;
            act_centre <= mode_q.centre;
            act_idle   <= mode_q.idle_high;
        end
    end

    assign clk_sel = mode_q.clk_sel;
    assign div_a   = div_a_q;
    assign div_b   = div_b_q;

endmodule

// File: rtl/pwm_tick_gen.sv
// pwm_tick_gen: channel tick source. A free-running prescaler provides TAPS
// power-of-two taps (select 0..TAPS-1). Select TAPS picks linear divider A and
// TAPS+1 picks divider B. Any other select ticks every cycle.
// Assumes TAPS >= 1 and TAPS+1 fits in the 4-bit select. A divider value of
// 0 behaves as 1.
module pwm_tick_gen #(
    parameter int TAPS  = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       clk_sel,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    output logic             tick
);

    localparam int PRE_W = (TAPS > 1) ? TAPS - 1 : 1;
    localparam int N_DIV = 2;

    logic [PRE_W-1:0] presc_q;
    logic [PRE_W-1:0] tap_mask;
    logic             tap_hit;
    logic [DIV_W-1:0] div_val [N_DIV];
    logic [N_DIV-1:0] div_hit;

    // Free-running prescaler shared by all taps.
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    // Mask of the low prescaler bits that must all be one for the chosen tap.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) tap_mask[i] = (i < 32'(clk_sel));
    end

    assign tap_hit    = (presc_q & tap_mask) == tap_mask;
    assign div_val[0] = div_a;
    assign div_val[1] = div_b;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        logic [DIV_W-1:0] cnt_q;
        logic [DIV_W-1:0] lim;
        assign lim        = (div_val[g] == '0) ? '0 : div_val[g] - 1'b1;
        assign div_hit[g] = (cnt_q >= lim);

        // Modulo-N counter of this linear divider.
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q <= '0;
            else if (div_hit[g]) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    // Route the selected source to the channel tick.
    always_comb begin
        if (32'(clk_sel) < TAPS)           tick = tap_hit;
        else if (32'(clk_sel) == TAPS)     tick = div_hit[0];
        else if (32'(clk_sel) == TAPS + 1) tick = div_hit[1];
        else                               tick = 1'b1;
    end

endmodule

// File: rtl/pwm_counter.sv
// pwm_counter: period counter. Edge mode: 0..prd-1 then wrap. Symmetric mode:
// up 0..prd-1, then prd..1 with the down flag set, then wrap to 0. 'wrap' is
// high in the ticking cycle that ends a period. period_evt is high in the
// first cycle of the new period.
// Assumes prd >= 1 and that prd and centre change only on a wrap.
module pwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          centre,
    input  logic [CW-1:0] prd,
    output logic [CW-1:0] cnt,
    output logic          down,
    output logic          wrap,
    output logic          period_evt
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          down_q, down_d;
    logic          evt_q;
    logic          at_top;

    assign at_top = (cnt_q >= prd - ONE);

    // Next counter state and period-end detection.
    always_comb begin
        cnt_d  = cnt_q;
        down_d = down_q;
        wrap   = 1'b0;
        if (tick) begin
            if (!centre) begin
                if (at_top) begin
                    cnt_d = '0;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (!down_q) begin
                if (at_top) begin
                    cnt_d  = prd;
                    down_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (cnt_q <= ONE) begin
                cnt_d  = '0;
                down_d = 1'b0;
                wrap   = 1'b1;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    // Counter, direction and period-event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
            evt_q  <= wrap;
        end
    end

    assign cnt        = cnt_q;
    assign down       = down_q;
    assign period_evt = evt_q;

endmodule

// File: rtl/pwm_compare.sv
// pwm_compare: turns counter state into the output level. The opposite level
// is driven from threshold prd-dty on the way up and above it on the way
// down, which gives 2*dty active ticks centred in a symmetric period.
// Assumes dty <= prd. A larger dty clamps the threshold to zero.
module pwm_compare #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic          down,
    input  logic [CW-1:0] prd,
    input  logic [CW-1:0] dty,
    input  logic          idle_high,
    output logic          level
);

    logic [CW-1:0] thr;
    logic          active;

    // Threshold and active-window decision.
    always_comb begin
        thr    = (dty > prd) ? '0 : prd - dty;
        active = down ? (cnt > thr) : (cnt >= thr);
        level  = idle_high ^ active;
    end

endmodule

// File: rtl/pwm_chan_gen.sv
// pwm_chan_gen: one PWM channel. The tick source paces the counter, the
// register file holds the settings and the comparator forms the output.
// Assumes synchronous active-low reset and DW >= 2*DIV_W.
module pwm_chan_gen #(
    parameter int DW      = 16,
    parameter int DIV_W   = 8,
    parameter int TAPS    = 11,
    parameter int RST_PRD = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pwm_out,
    output logic          period_evt
);

    logic [3:0]       clk_sel;
    logic [DIV_W-1:0] div_a;
    logic [DIV_W-1:0] div_b;
    logic [DW-1:0]    act_prd;
    logic [DW-1:0]    act_dty;
    logic             act_centre;
    logic             act_idle;
    logic             tick;
    logic [DW-1:0]    cnt;
    logic             down;
    logic             wrap;

    pwm_regs #(.DW(DW), .DIV_W(DIV_W), .RST_PRD(RST_PRD)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load       (wrap),
        .clk_sel    (clk_sel),
        .div_a      (div_a),
        .div_b      (div_b),
        .act_prd    (act_prd),
        .act_dty    (act_dty),
        .act_centre (act_centre),
        .act_idle   (act_idle)
    );

    pwm_tick_gen #(.TAPS(TAPS), .DIV_W(DIV_W)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .div_a   (div_a),
        .div_b   (div_b),
        .tick    (tick)
    );

    pwm_counter #(.CW(DW)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .centre     (act_centre),
        .prd        (act_prd),
        .cnt        (cnt),
        .down       (down),
        .wrap       (wrap),
        .period_evt (period_evt)
    );

    pwm_compare #(.CW(DW)) cmp_i (
        .cnt       (cnt),
        .down      (down),
        .prd       (act_prd),
        .dty       (act_dty),
        .idle_high (act_idle),
        .level     (pwm_out)
    );

endmodule

// File: rtl/pwm_chan_chk.sv
// pwm_chan_chk: property checker bound into pwm_chan_gen. It watches counter
// range, tick pacing, event placement, duty extremes and working-set hold.
module pwm_chan_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wrap,
    input logic [DW-1:0] cnt,
    input logic          down,
    input logic [DW-1:0] act_prd,
    input logic [DW-1:0] act_dty,
    input logic          act_centre,
    input logic          act_idle,
    input logic          pwm_out,
    input logic          period_evt
);

    assert_cnt_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !act_centre |-> (cnt < act_prd));

    assert_cnt_sym_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_centre |-> (cnt <= act_prd));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    assert_evt_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |-> (cnt == '0 && !down));

    assert_duty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_dty == '0) |-> (pwm_out == act_idle));

    assert_duty_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_dty == act_prd) |-> (pwm_out != act_idle));

    assert_set_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_prd) && $stable(act_dty)));

endmodule

bind pwm_chan_gen pwm_chan_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wrap       (wrap),
    .cnt        (cnt),
    .down       (down),
    .act_prd    (act_prd),
    .act_dty    (act_dty),
    .act_centre (act_centre),
    .act_idle   (act_idle),
    .pwm_out    (pwm_out),
    .period_evt (period_evt)
);

// File: tb/pwm_chan_gen_tb_top.sv
`timescale 1ns/1ps
// Directed bench: each task sets up one scenario and checks whole periods
// cycle by cycle against the waveform formula from the requirements.
module pwm_chan_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic        period_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwm_chan_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .period_evt (period_evt)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait at negedges until the period pulse is seen.
    task automatic wait_evt();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (period_evt) return;
        end
    endtask

    // Program all registers, then settle so the new set is fully active.
    task automatic cfg(input int sel, input bit ctr, input bit idle,
                       input int da, input int db, input int p, input int d);
        wr(2'd3, 16'((db << 8) | da));
        wr(2'd0, 16'(sel | (int'(ctr) << 4) | (int'(idle) << 5)));
        wr(2'd1, 16'(p));
        wr(2'd2, 16'(d));
        wait_evt();
        wait_evt();
        wait_evt();
    endtask

    // Check one period starting at the current negedge (pulse high here).
    // Optionally write register wa with wd at cycle offset wo.
    task automatic check_period(input int x, input int p, input int d, input bit ctr,
                                input bit idle, input string req,
                                input int wo, input logic [1:0] wa, input logic [15:0] wd);
        int len;
        int bad_m;
        int bad_act;
        int bad_exp;
        int evt_bad;
        len     = ctr ? 2 * x * p : x * p;
        bad_m   = -1;
        bad_act = 0;
        bad_exp = 0;
        evt_bad = 0;
        for (int m = 0; m < len; m++) begin
            int  t;
            bit  inv;
            bit  e;
            if (m > 0) @(negedge clk);
            t   = m / x;
            inv = ctr ? (t >= p - d && t <= p + d - 1) : (t >= p - d);
            e   = idle ^ inv;
            if (pwm_out !== e && bad_m < 0) begin
                bad_m   = m;
                bad_act = int'(pwm_out);
                bad_exp = int'(e);
            end
            if ((m == 0 && period_evt !== 1'b1) || (m > 0 && period_evt !== 1'b0))
                evt_bad++;
            if (m == wo) begin
                wr_en   = 1'b1;
                wr_addr = wa;
                wr_data = wd;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (bad_m >= 0)
            $display("  mismatch at cycle offset %0d of period", bad_m);
        check(bad_m < 0, {req, " waveform"}, bad_act, bad_exp);
        check(evt_bad == 0 && period_evt === 1'b1, "R9 period pulse placement",
              evt_bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(pwm_out === 1'b0, "R1 output low in reset", int'(pwm_out), 0);
        check(period_evt === 1'b0, "R1 no pulse in reset", int'(period_evt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // defaults: tick every cycle, period 1, so every cycle starts a period
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(pwm_out === 1'b0 && period_evt === 1'b1, "R1 default run",
                  int'({pwm_out, period_evt}), 1);
        end
    endtask

    task automatic t_taps();
        cfg(0, 0, 0, 0, 0, 5, 2);
        check_period(1, 5, 2, 0, 0, "R4 tap0", -1, 2'd0, 16'd0);
        cfg(3, 0, 0, 0, 0, 4, 1);
        check_period(8, 4, 1, 0, 0, "R2 tap3", -1, 2'd0, 16'd0);
        cfg(10, 0, 0, 0, 0, 2, 1);
        check_period(1024, 2, 1, 0, 0, "R2 tap10", -1, 2'd0, 16'd0);
    endtask

    task automatic t_dividers();
        cfg(11, 0, 0, 3, 5, 4, 3);
        check_period(3, 4, 3, 0, 0, "R3 divider A", -1, 2'd0, 16'd0);
        cfg(12, 1, 0, 3, 5, 3, 2);
        check_period(5, 3, 2, 1, 0, "R3 divider B symmetric", -1, 2'd0, 16'd0);
        cfg(11, 0, 0, 0, 5, 3, 1);
        check_period(1, 3, 1, 0, 0, "R3 divider zero", -1, 2'd0, 16'd0);
        cfg(14, 0, 0, 3, 5, 3, 2);
        check_period(1, 3, 2, 0, 0, "R3 unused select", -1, 2'd0, 16'd0);
    endtask

    task automatic t_centre();
        cfg(1, 1, 0, 0, 0, 6, 2);
        check_period(2, 6, 2, 1, 0, "R5 symmetric tap1", -1, 2'd0, 16'd0);
        cfg(0, 1, 0, 0, 0, 1, 1);
        check_period(1, 1, 1, 1, 0, "R5 symmetric period 1", -1, 2'd0, 16'd0);
    endtask

    task automatic t_polarity();
        cfg(0, 0, 1, 0, 0, 5, 3);
        check_period(1, 5, 3, 0, 1, "R6 idle high edge", -1, 2'd0, 16'd0);
        cfg(0, 1, 1, 0, 0, 4, 1);
        check_period(1, 4, 1, 1, 1, "R6 idle high symmetric", -1, 2'd0, 16'd0);
    endtask

    task automatic t_extremes();
        cfg(0, 0, 0, 0, 0, 6, 0);
        check_period(1, 6, 0, 0, 0, "R7 duty zero", -1, 2'd0, 16'd0);
        cfg(0, 0, 0, 0, 0, 6, 6);
        check_period(1, 6, 6, 0, 0, "R7 duty full edge", -1, 2'd0, 16'd0);
        cfg(0, 1, 0, 0, 0, 4, 4);
        check_period(1, 4, 4, 1, 0, "R7 duty full symmetric", -1, 2'd0, 16'd0);
    endtask

    task automatic t_shadow();
        cfg(0, 0, 0, 0, 0, 8, 2);
        // mid-period write: rest of this period keeps duty 2
        check_period(1, 8, 2, 0, 0, "R8 mid write old", 3, 2'd2, 16'd6);
        check_period(1, 8, 6, 0, 0, "R8 mid write new", -1, 2'd0, 16'd0);
        // write on the wrap edge: deferred one more period
        check_period(1, 8, 6, 0, 0, "R8 edge write current", 7, 2'd2, 16'd1);
        check_period(1, 8, 6, 0, 0, "R8 edge write deferred", -1, 2'd0, 16'd0);
        check_period(1, 8, 1, 0, 0, "R8 edge write applied", -1, 2'd0, 16'd0);
        // alignment change mid-period
        check_period(1, 8, 1, 0, 0, "R8 align write old", 2, 2'd0, 16'h0010);
        check_period(1, 8, 1, 1, 0, "R8 align write new", -1, 2'd0, 16'd0);
    endtask

    initial begin
        t_reset();
        t_taps();
        t_dividers();
        t_centre();
        t_polarity();
        t_extremes();
        t_shadow();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule